// File: doc/BRIEF.md
# Auxiliary Channel Reply Classifier

This block sits behind the receiver of a sideband auxiliary channel and turns one finished reply into a verdict. A one-cycle `start` opens a wait window. While the window is open, the receiver presents the reply on a single cycle marked by `rx_done`: a byte count, a flat byte buffer and a set of receive-error flags. The block then gives three things: a channel result (success, timeout or invalid reply), a decoded reply status taken from the upper nibble of the first byte, and the number of payload bytes that follow that first byte. The whole verdict is marked by a one-cycle `res_valid` pulse.

When the reply is an acknowledge, the payload bytes (every byte after the status byte) are then streamed out one per cycle on `dout_*`. If no reply arrives before the wait limit expires, the block reports a timeout. A `fault` flag marks an empty reply, or an expired wait, that was not explained by a hot-unplug of the sink. All outputs hold their value until the next verdict.

Top module: `aux_reply_decoder`

## Requirements
- R1: After reset, `res_valid`, `dout_valid`, `dout_last` and `fault` are 0, `result` is 0, `status` is 7 and `data_count` is 0.
- R2: If `rx_done` is not seen on any of the TIMEOUT_CYC cycles that follow the `start` cycle, then `res_valid` pulses on the cycle after the last of them, with `result`=1 (timeout), `status`=7 and `data_count`=0. A done on the last of those cycles is still classified as a reply.
- R3: At done, a set `rx_timeout` gives `result`=1, whatever other flags are set.
- R4: At done, with `rx_timeout` clear, any of `rx_inv_stop`, `rx_no_det`, `rx_inv_high` or `rx_inv_low` gives `result`=2 (invalid reply).
- R5: At done, with no error flags, a byte count of 0 or a byte count above MAX_BYTES gives `result`=2. Any other count gives `result`=0 (success).
- R6: On success, `data_count` is the byte count minus one. On any other result, `data_count` is 0 and `status` is 7.
- R7: On success, `status` is decoded from bits 7:4 of buffer byte 0 (bits 7:0 of `rx_bytes`): 0→0 ACK, 1→1 NACK, 2→2 DEFER, 4→3 I2C NACK, 8→4 I2C DEFER. Any other nibble gives 7 (invalid).
- R8: Only when `result`=0 and `status`=0 are buffer bytes 1 to count-1 (byte i at `rx_bytes[8i+7:8i]`) driven on `dout_byte`, in order, one per cycle. The stream starts on the `res_valid` cycle, and `dout_last` marks the final byte. Any other reply streams nothing.
- R9: `fault` is 1 after a done with no error flags and a zero count, or after an expired wait, in each case only when `hpd_discon` is 0 at that time. Otherwise `fault` is 0.
- R10: `rx_min_viol` has no effect on the result, status, count or stream.
- R11: `res_valid` is a single-cycle pulse. `result`, `status`, `data_count` and `fault` change only with it. `rx_done` outside a wait window is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| start | input | 1 | Opens a wait window (accepted when idle) |
| rx_done | input | 1 | Reply present this cycle |
| rx_count | input | CW | Received byte count, status byte included |
| rx_bytes | input | 8*MAX_BYTES | Reply buffer, byte i at bits 8i+7:8i |
| rx_timeout | input | 1 | Receive timeout flag |
| rx_inv_stop | input | 1 | Invalid stop pattern |
| rx_no_det | input | 1 | No reply detected |
| rx_inv_high | input | 1 | Invalid high symbol |
| rx_inv_low | input | 1 | Invalid low symbol |
| rx_min_viol | input | 1 | Minimum-count debug flag (ignored) |
| hpd_discon | input | 1 | Sink unplugged |
| res_valid | output | 1 | New verdict pulse |
| result | output | 2 | 0 success, 1 timeout, 2 invalid reply |
| status | output | 3 | Decoded reply status |
| data_count | output | CW | Payload byte count |
| fault | output | 1 | Unexplained empty reply or expired wait |
| dout_valid | output | 1 | Payload byte valid |
| dout_byte | output | 8 | Payload byte |
| dout_last | output | 1 | Final payload byte |

## Verification
The bench aims at the edges of the wait window. A done on the very last allowed cycle must be classified, and silence must give a timeout exactly one cycle later; an off-by-one counter would turn the first case into a timeout or move the pulse. It mixes error flags so that a wrong priority shows up as an invalid result where a timeout belongs. It feeds nibbles such as 3 and F, which a loose decode would take as a known code. Zero, one, maximum and oversize counts check the stream length and the `dout_last` marker, and the hot-unplug pairings check that `fault` is masked only where it should be.

// File: rtl/aux_reply_decoder.sv
module aux_reply_decoder #(
  parameter int MAX_BYTES   = 17,
  parameter int TIMEOUT_CYC = 64
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   start,
  input  logic                   rx_done,
  input  logic [$clog2(MAX_BYTES+1)-1:0] rx_count,
  input  logic [8*MAX_BYTES-1:0] rx_bytes,
  input  logic                   rx_timeout,
  input  logic                   rx_inv_stop,
  input  logic                   rx_no_det,
  input  logic                   rx_inv_high,
  input  logic                   rx_inv_low,
  input  logic                   rx_min_viol,
  input  logic                   hpd_discon,
  output logic                   res_valid,
  output logic [1:0]             result,
  output logic [2:0]             status,
  output logic [$clog2(MAX_BYTES+1)-1:0] data_count,
  output logic                   fault,
  output logic                   dout_valid,
  output logic [7:0]             dout_byte,
  output logic                   dout_last
);
  localparam int CW = $clog2(MAX_BYTES+1);
  localparam int TW = (TIMEOUT_CYC > 1) ? $clog2(TIMEOUT_CYC) : 1;
  localparam logic [1:0] RES_OK = 2'd0, RES_TO = 2'd1, RES_BAD = 2'd2;
  localparam logic [2:0] ST_ACK = 3'd0, ST_NACK = 3'd1, ST_DEFER = 3'd2,
                         ST_I2C_NACK = 3'd3, ST_I2C_DEFER = 3'd4, ST_BAD = 3'd7;

  typedef enum logic [1:0] {IDLE, WAIT, STREAM} phase_t;
  phase_t phase;

  logic [TW-1:0]          tcnt;
  logic [CW-1:0]          idx;
  logic [8*MAX_BYTES-1:0] buf_q;

  logic       sym_err, cnt_bad, go_stream, unused_ok;
  logic [1:0] new_res;
  logic [2:0] dec_st, new_st;
  logic [CW-1:0] new_cnt;

  assign unused_ok = rx_min_viol;
  assign sym_err   = rx_inv_stop | rx_no_det | rx_inv_high | rx_inv_low;
  assign cnt_bad   = (rx_count == '0) || (rx_count > CW'(MAX_BYTES));

  always_comb begin
    case (rx_bytes[7:4])
      4'h0:    dec_st = ST_ACK;
      4'h1:    dec_st = ST_NACK;
      4'h2:    dec_st = ST_DEFER;
      4'h4:    dec_st = ST_I2C_NACK;
      4'h8:    dec_st = ST_I2C_DEFER;
      default: dec_st = ST_BAD;
    endcase
  end

  assign new_res   = rx_timeout ? RES_TO : (sym_err || cnt_bad) ? RES_BAD : RES_OK;
  assign new_st    = (new_res == RES_OK) ? dec_st : ST_BAD;
  assign new_cnt   = (new_res == RES_OK) ? rx_count - 1'b1 : '0;
  assign go_stream = (new_res == RES_OK) && (dec_st == ST_ACK) && (new_cnt != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase      <= IDLE;
      tcnt       <= '0;
      idx        <= '0;
      buf_q      <= '0;
      res_valid  <= 1'b0;
      result     <= RES_OK;
      status     <= ST_BAD;
      data_count <= '0;
      fault      <= 1'b0;
    end else begin
      res_valid <= 1'b0;
      case (phase)
        IDLE: if (start) begin
          phase <= WAIT;
          tcnt  <= '0;
        end
        WAIT: begin
          if (rx_done) begin
            res_valid  <= 1'b1;
            result     <= new_res;
            status     <= new_st;
            data_count <= new_cnt;
            fault      <= !rx_timeout && !sym_err && (rx_count == '0) && !hpd_discon;
            buf_q      <= rx_bytes;
            idx        <= CW'(1);
            phase      <= go_stream ? STREAM : IDLE;
          end else if (tcnt == TW'(TIMEOUT_CYC-1)) begin
            res_valid  <= 1'b1;
            result     <= RES_TO;
            status     <= ST_BAD;
            data_count <= '0;
            fault      <= !hpd_discon;
            phase      <= IDLE;
          end else begin
            tcnt <= tcnt + 1'b1;
          end
        end
        STREAM: begin
          if (idx == data_count) phase <= IDLE;
          else idx <= idx + 1'b1;
        end
        default: phase <= IDLE;
      endcase
    end
  end

  assign dout_valid = (phase == STREAM);
  assign dout_byte  = dout_valid ? buf_q[8*idx +: 8] : 8'h00;
  assign dout_last  = dout_valid && (idx == data_count);
endmodule

// File: rtl/aux_reply_decoder_chk.sv
module aux_reply_decoder_chk #(
  parameter int CW = 5,
  parameter int MAX_BYTES = 17
) (
  input logic          clk,
  input logic          rst_n,
  input logic          res_valid,
  input logic [1:0]    result,
  input logic [2:0]    status,
  input logic [CW-1:0] data_count,
  input logic          fault,
  input logic          dout_valid,
  input logic          dout_last
);
  // R11
  res_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |=> !res_valid);
  // R11
  verdict_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !res_valid |-> ($stable(result) && $stable(status) && $stable(data_count) && $stable(fault)));
  // R8
  stream_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dout_valid |-> (result == 2'd0 && status == 3'd0));
  // R8
  last_in_stream_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dout_last |-> dout_valid);
  // R9
  fault_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fault |-> (result != 2'd0));
  // R6
  fail_fields_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && result != 2'd0) |-> (status == 3'd7 && data_count == '0));
  // R6
  count_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && result == 2'd0) |-> (data_count < CW'(MAX_BYTES)));
endmodule

bind aux_reply_decoder aux_reply_decoder_chk #(.CW(CW), .MAX_BYTES(MAX_BYTES)) u_chk (
  .clk(clk), .rst_n(rst_n), .res_valid(res_valid), .result(result),
  .status(status), .data_count(data_count), .fault(fault),
  .dout_valid(dout_valid), .dout_last(dout_last)
);

// File: tb/tb_aux_reply_decoder.sv
module tb_aux_reply_decoder;
  localparam int MAXB = 17;
  localparam int TOC  = 20;
  localparam int CW   = $clog2(MAXB+1);

  logic clk = 0, rst_n = 0;
  logic start = 0, rx_done = 0;
  logic [CW-1:0] rx_count = '0;
  logic [8*MAXB-1:0] rx_bytes = '0;
  logic rx_timeout = 0, rx_inv_stop = 0, rx_no_det = 0, rx_inv_high = 0;
  logic rx_inv_low = 0, rx_min_viol = 0, hpd_discon = 0;
  logic res_valid, fault, dout_valid, dout_last;
  logic [1:0] result;
  logic [2:0] status;
  logic [CW-1:0] data_count;
  logic [7:0] dout_byte;

  int checks = 0, fails = 0;
  bit done_flag = 0;

  always #5 clk = ~clk;

  aux_reply_decoder #(.MAX_BYTES(MAXB), .TIMEOUT_CYC(TOC)) dut (
    .clk(clk), .rst_n(rst_n), .start(start), .rx_done(rx_done),
    .rx_count(rx_count), .rx_bytes(rx_bytes), .rx_timeout(rx_timeout),
    .rx_inv_stop(rx_inv_stop), .rx_no_det(rx_no_det), .rx_inv_high(rx_inv_high),
    .rx_inv_low(rx_inv_low), .rx_min_viol(rx_min_viol), .hpd_discon(hpd_discon),
    .res_valid(res_valid), .result(result), .status(status),
    .data_count(data_count), .fault(fault), .dout_valid(dout_valid),
    .dout_byte(dout_byte), .dout_last(dout_last));

  // {count, nibble, flags{hpd,min,inv_low,inv_high,no_det,inv_stop,rx_to}, exp result, exp status, exp count, exp fault}
  localparam int NV = 19;
  localparam logic [26:0] VEC [NV] = '{
    {5'd3,  4'h0, 7'b0000000, 2'd0, 3'd0, 5'd2,  1'b0},
    {5'd17, 4'h0, 7'b0000000, 2'd0, 3'd0, 5'd16, 1'b0},
    {5'd1,  4'h0, 7'b0000000, 2'd0, 3'd0, 5'd0,  1'b0},
    {5'd2,  4'h1, 7'b0000000, 2'd0, 3'd1, 5'd1,  1'b0},
    {5'd1,  4'h2, 7'b0000000, 2'd0, 3'd2, 5'd0,  1'b0},
    {5'd1,  4'h4, 7'b0000000, 2'd0, 3'd3, 5'd0,  1'b0},
    {5'd2,  4'h8, 7'b0000000, 2'd0, 3'd4, 5'd1,  1'b0},
    {5'd1,  4'h3, 7'b0000000, 2'd0, 3'd7, 5'd0,  1'b0},
    {5'd1,  4'hF, 7'b0000000, 2'd0, 3'd7, 5'd0,  1'b0},
    {5'd3,  4'h0, 7'b0011111, 2'd1, 3'd7, 5'd0,  1'b0},
    {5'd3,  4'h0, 7'b0000100, 2'd2, 3'd7, 5'd0,  1'b0},
    {5'd3,  4'h0, 7'b0001000, 2'd2, 3'd7, 5'd0,  1'b0},
    {5'd3,  4'h0, 7'b0010000, 2'd2, 3'd7, 5'd0,  1'b0},
    {5'd3,  4'h0, 7'b0000010, 2'd2, 3'd7, 5'd0,  1'b0},
    {5'd0,  4'h0, 7'b0000000, 2'd2, 3'd7, 5'd0,  1'b1},
    {5'd0,  4'h0, 7'b1000000, 2'd2, 3'd7, 5'd0,  1'b0},
    {5'd18, 4'h0, 7'b0000000, 2'd2, 3'd7, 5'd0,  1'b0},
    {5'd2,  4'h0, 7'b0100000, 2'd0, 3'd0, 5'd1,  1'b0},
    {5'd0,  4'h0, 7'b0000100, 2'd2, 3'd7, 5'd0,  1'b0}
  };

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic set_flags(input logic [6:0] f);
    {hpd_discon, rx_min_viol, rx_inv_low, rx_inv_high, rx_no_det, rx_inv_stop, rx_timeout} = f;
  endtask

  task automatic fill(input logic [3:0] nib, input int seed);
    for (int i = 0; i < MAXB; i++)
      rx_bytes[8*i +: 8] = (i == 0) ? {nib, 4'hA} : 8'(seed + i*7);
  endtask

  // start, d idle cycles, one done cycle; returns at the negedge after the done edge
  task automatic reply(input logic [4:0] cnt, input logic [3:0] nib, input logic [6:0] f,
                       input int d, input int seed);
    @(negedge clk) start = 1;
    @(negedge clk) start = 0;
    repeat (d) @(negedge clk);
    rx_count = CW'(cnt); fill(nib, seed); set_flags(f); rx_done = 1;
    @(negedge clk) rx_done = 0; set_flags(7'b0);
  endtask

  task automatic observe(input int seed, input int exp_n, input string req);
    int n = 0;
    for (int j = 0; j < MAXB + 3; j++) begin
      if (j > 0 && res_valid) check(0, "R11 pulse", 1, 0);
      if (dout_valid) begin
        n++;
        check(dout_byte == 8'(seed + n*7), req, dout_byte, 8'(seed + n*7));
        check(dout_last == (n == exp_n), "R8 last", dout_last, (n == exp_n));
      end
      @(negedge clk);
    end
    check(n == exp_n, "R8 stream length", n, exp_n);
  endtask

  initial begin
    #2_000_000;
    fails++;
    $display("FAIL watchdog actual=hung expected=finish");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    check(!res_valid && !dout_valid && !dout_last && !fault, "R1 flags", {res_valid,dout_valid,dout_last,fault}, 0);
    check(result == 0 && status == 7 && data_count == 0, "R1 fields", {result,status,data_count}, {2'd0,3'd7,5'd0});
    rst_n = 1;
    @(negedge clk);

    foreach (VEC[k]) begin
      logic [26:0] v;
      int sd, en;
      v  = VEC[k];
      sd = k * 16 + 3;
      reply(v[26:22], v[21:18], v[17:11], k % 4, sd);
      check(res_valid, "R11 res_valid", res_valid, 1);
      check(result == v[10:9], "R3 R4 R5 result", result, v[10:9]);
      check(status == v[8:6], "R7 status", status, v[8:6]);
      check(data_count == CW'(v[5:1]), "R6 count", data_count, v[5:1]);
      check(fault == v[0], "R9 R10 fault", fault, v[0]);
      en = (v[10:9] == 0 && v[8:6] == 0) ? int'(v[5:1]) : 0;
      observe(sd, en, "R8 payload");
    end

    // R11 hold: outputs unchanged with no new verdict
    begin
      logic [1:0] r0; logic [2:0] s0; logic [CW-1:0] c0;
      r0 = result; s0 = status; c0 = data_count;
      repeat (5) @(negedge clk);
      check(result == r0 && status == s0 && data_count == c0, "R11 hold", result, r0);
      // R11 done while idle ignored
      rx_count = CW'(3); fill(4'h0, 50); rx_done = 1;
      @(negedge clk) rx_done = 0;
      check(!res_valid && !dout_valid, "R11 idle done", res_valid, 0);
      repeat (2) @(negedge clk);
      check(result == r0 && status == s0 && data_count == c0, "R11 idle done hold", data_count, c0);
    end

    // R2 done on the last allowed cycle is classified
    reply(5'd2, 4'h0, 7'b0, TOC - 1, 90);
    check(res_valid && result == 0 && status == 0, "R2 last-cycle done", result, 0);
    observe(90, 1, "R2 R8 payload");

    // R2 silence gives timeout, fault with hpd low
    for (int h = 0; h < 2; h++) begin
      int at = -1;
      hpd_discon = h[0];
      @(negedge clk) start = 1;
      @(negedge clk) start = 0;
      for (int k = 1; k <= TOC + 3; k++) begin
        @(negedge clk);
        if (res_valid && at < 0) begin
          at = k;
          check(result == 1 && status == 7 && data_count == 0, "R2 timeout fields", result, 1);
          check(fault == !h[0], "R9 timeout fault", fault, !h[0]);
        end
      end
      check(at == TOC, "R2 timeout cycle", at, TOC);
      hpd_discon = 0;
    end

    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule